// File: doc/BRIEF.md
# Oversampled I2C Register Target

This block is the two-wire serial target for a small measurement device. It samples the bus clock and data lines with the much faster system clock, recovers START, repeated START and STOP, and serves twelve byte-wide registers through an internal register pointer. Ten of those bytes are read-only results supplied by the surrounding logic. The other two are read/write control bytes. Control 1 carries a mode field, a self-clearing latch-reset command, a shutdown bit and a channel select. Control 2 carries two delay-select bits.

Sixteen bus addresses come from two 2-bit strap codes that sit under a fixed 3-bit prefix. A write sets the pointer and then stores one or more data bytes. A read sets the pointer with a write phase, then issues a repeated START with the read bit set and clocks bytes out for as long as the controller acknowledges. The block drives its data pin only through an open-drain enable (`sdaOe` high pulls the line low).

Before any edge is detected, each bus line passes through a two-flop synchronizer and a short stability filter.

Top module: `sense_reg_target`

## Requirements
- R1: The 7-bit address is {3'b111, strapA, strapB}, so the address byte is 0xE0 to 0xFF with the read/write flag in bit 0. On a match the target pulls SDA low during the ninth clock.
- R2: After an address mismatch the target leaves SDA released until the next START and changes no register.
- R3: A write phase takes the first data byte as the register pointer and stores each later byte at the pointer. Control 1 is at 0x0A and control 2 at 0x0B. Control bytes change only on such a write.
- R4: During a burst write the pointer advances after each byte and stays at 0x0B once it gets there.
- R5: After the pointer is set, a repeated START with the read flag returns the byte at the pointer, most significant bit first.
- R6: A burst read continues while the controller acknowledges, with the pointer advancing and saturating at 0x0B. After a NACK the target releases SDA.
- R7: Registers 0x00 to 0x09 return byte i of `resultBytes`, bits 8i+7 down to 8i. Writes to them are acknowledged and have no effect.
- R8: Writing 1 to bit 4 of control 1 raises `latchClr` for exactly one system cycle. Bit 4 always reads 0.
- R9: In control 2 only bits 3 and 2 are writable. All other bits read 0.
- R10: Reset clears both control bytes to 0x00 and releases SDA.
- R11: A pointer byte greater than 0x0B is taken as 0x0B.
- R12: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High pulls the data line low |
| strapA | input | 2 | Address strap code, address bits 3:2 |
| strapB | input | 2 | Address strap code, address bits 1:0 |
| resultBytes | input | 80 | Ten read-only result bytes, byte i at bits 8i+7:8i |
| ctrl1Out | output | 8 | Control 1: mode 7:5, shutdown 3, channel 2:0 |
| ctrl2Out | output | 8 | Control 2: fault delay select 3, retry delay select 2 |
| latchClr | output | 1 | One-cycle pulse when a 1 is written to control 1 bit 4 |

## Verification
The bench builds the block with its default parameters: ten result bytes and a three-cycle filter. With twelve registers, a burst of only two or three bytes starting at 0x0A already reaches pointer saturation, for both reads and writes. The three-cycle filter plus the synchronizer leaves a bus half-period of forty system cycles with a wide margin, so every acknowledge and data bit is sampled well after the target has settled.

// File: rtl/sense_reg_pkg.sv
package sense_reg_pkg;
  localparam int ByteW = 8;

  typedef struct packed {
    logic             ptrLoad;
    logic             wrEn;
    logic             rdAdv;
    logic [ByteW-1:0] data;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK, ST_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} phase_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic q
);
  localparam int CntW = $clog2(FILT_LEN + 1);
  localparam logic [CntW-1:0] CntLast = CntW'(FILT_LEN - 1);

  logic [1:0]      syncQ;
  logic [CntW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= 2'b11;
      cnt   <= '0;
      q     <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], din};
      if (syncQ[1] == q) begin
        cnt <= '0;
      end else if (cnt == CntLast) begin
        q   <= syncQ[1];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import sense_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [6:0] devAddr,
  input  logic [7:0] rdData,
  output strobe_t    strb,
  output logic       sdaOe
);
  bus_state_t state;
  phase_t     phase;
  logic       sclPrev, sdaPrev, readMode, mAck;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, txShift;
  logic       sclRise, sclFall, startC, stopC;

  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startC  = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopC   = sclF & sclPrev & ~sdaPrev & sdaF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= PH_ADDR;
      sclPrev <= 1'b1; sdaPrev <= 1'b1;
      readMode <= 1'b0; mAck <= 1'b0; bitCnt <= '0;
      shiftIn <= '0; txShift <= '0; sdaOe <= 1'b0; strb <= '0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      strb.ptrLoad <= 1'b0;
      strb.wrEn    <= 1'b0;
      strb.rdAdv   <= 1'b0;
      if (startC) begin
        state <= ST_RECV; phase <= PH_ADDR; bitCnt <= '0; sdaOe <= 1'b0;
      end else if (stopC) begin
        state <= ST_IDLE; sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftIn <= {shiftIn[6:0], sdaF};
              bitCnt  <= bitCnt + 1'b1;
            end
            if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (shiftIn[7:1] == devAddr) begin
                    state <= ST_ACK; sdaOe <= 1'b1;
                    readMode <= shiftIn[0]; phase <= PH_PTR;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                PH_PTR: begin
                  strb.ptrLoad <= 1'b1; strb.data <= shiftIn;
                  state <= ST_ACK; sdaOe <= 1'b1; phase <= PH_DATA;
                end
                default: begin
                  strb.wrEn <= 1'b1; strb.data <= shiftIn;
                  state <= ST_ACK; sdaOe <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readMode) begin
                state <= ST_SEND; txShift <= rdData;
                sdaOe <= ~rdData[7]; strb.rdAdv <= 1'b1;
              end else begin
                state <= ST_RECV; sdaOe <= 1'b0;
              end
            end
          end
          ST_SEND: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                state <= ST_MACK; sdaOe <= 1'b0;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaOe   <= ~txShift[6];
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (sclRise) mAck <= ~sdaF;
            if (sclFall) begin
              bitCnt <= '0;
              if (mAck) begin
                state <= ST_SEND; txShift <= rdData;
                sdaOe <= ~rdData[7]; strb.rdAdv <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/reg_datapath.sv
module reg_datapath
  import sense_reg_pkg::*;
#(
  parameter int NUM_RESULT = 10,
  parameter logic [7:0] CTRL2_MASK = 8'h0C,
  parameter int LATCH_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [NUM_RESULT*8-1:0] resultBytes,
  output logic [7:0]              rdData,
  output logic [7:0]              ctrl1Out,
  output logic [7:0]              ctrl2Out,
  output logic                    latchClr
);
  localparam int PtrW = $clog2(NUM_RESULT + 2);
  localparam logic [PtrW-1:0] Ctrl1Idx = PtrW'(NUM_RESULT);
  localparam logic [PtrW-1:0] LastIdx  = PtrW'(NUM_RESULT + 1);
  localparam logic [7:0]      LastByte = 8'(NUM_RESULT + 1);

  logic [PtrW-1:0] ptr;
  logic [PtrW-1:0] ptrNext;

  assign ptrNext = (ptr == LastIdx) ? ptr : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0; ctrl1Out <= '0; ctrl2Out <= '0; latchClr <= 1'b0;
    end else begin
      latchClr <= 1'b0;
      if (strb.ptrLoad) begin
        ptr <= (strb.data > LastByte) ? LastIdx : strb.data[PtrW-1:0];
      end else if (strb.wrEn) begin
        if (ptr == Ctrl1Idx) begin
          ctrl1Out <= strb.data & ~(8'h01 << LATCH_BIT);
          latchClr <= strb.data[LATCH_BIT];
        end else if (ptr == LastIdx) begin
          ctrl2Out <= strb.data & CTRL2_MASK;
        end
        ptr <= ptrNext;
      end else if (strb.rdAdv) begin
        ptr <= ptrNext;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_RESULT; i++) begin
      if (ptr == PtrW'(i)) rdData = resultBytes[8*i +: 8];
    end
    if (ptr == Ctrl1Idx) rdData = ctrl1Out;
    if (ptr == LastIdx)  rdData = ctrl2Out;
  end
endmodule

// File: rtl/sense_reg_target.sv
module sense_reg_target
  import sense_reg_pkg::*;
#(
  parameter int NUM_RESULT = 10,
  parameter int FILT_LEN = 3,
  parameter logic [2:0] ADDR_HI = 3'b111
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaOe,
  input  logic [1:0]              strapA,
  input  logic [1:0]              strapB,
  input  logic [NUM_RESULT*8-1:0] resultBytes,
  output logic [7:0]              ctrl1Out,
  output logic [7:0]              ctrl2Out,
  output logic                    latchClr
);
  localparam int NumLines = 2;

  logic [NumLines-1:0] rawLines, filtLines;
  strobe_t             strb;
  logic [7:0]          rdData;
  logic                regWrite;

  assign rawLines = {sdaIn, sclIn};
  assign regWrite = strb.wrEn;

  for (genvar g = 0; g < NumLines; g++) begin : g_line
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .din(rawLines[g]), .q(filtLines[g])
    );
  end

  bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(filtLines[0]), .sdaF(filtLines[1]),
    .devAddr({ADDR_HI, strapA, strapB}), .rdData(rdData),
    .strb(strb), .sdaOe(sdaOe)
  );

  reg_datapath #(.NUM_RESULT(NUM_RESULT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .resultBytes(resultBytes),
    .rdData(rdData), .ctrl1Out(ctrl1Out), .ctrl2Out(ctrl2Out),
    .latchClr(latchClr)
  );
endmodule

// File: rtl/sense_reg_checks.sv
module sense_reg_checks (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic [7:0] ctrl1Out,
  input logic [7:0] ctrl2Out,
  input logic       latchClr,
  input logic       regWrite
);
  p_oe_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
  p_oe_fall_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);
  p_latch_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    latchClr |=> !latchClr);
  p_latch_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    latchClr |-> $past(regWrite));
  p_latch_bit_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl1Out[4]);
  p_ctrl2_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl2Out & 8'hF3) == 8'h00);
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |=> ($stable(ctrl1Out) && $stable(ctrl2Out)));
endmodule

bind sense_reg_target sense_reg_checks u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .ctrl1Out(ctrl1Out), .ctrl2Out(ctrl2Out), .latchClr(latchClr),
  .regWrite(regWrite)
);

// File: tb/sense_reg_target_test.sv
module sense_reg_target_test;
  localparam int Q = 20;
  localparam int NumRes = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strapA = 2'b10, strapB = 2'b01;
  logic [NumRes*8-1:0] resultBytes;
  logic sdaOe, latchClr;
  logic [7:0] ctrl1Out, ctrl2Out;
  wire sdaBus = sdaM & ~sdaOe;

  int vecCount = 0, missCount = 0, latchCount = 0;
  logic oeSeen = 1'b0, finished = 1'b0;
  logic [7:0] addrW = 8'hF2, addrR = 8'hF3;
  logic [7:0] rdBuf [4];
  logic ackAll;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NumRes; g++) begin : g_res
    assign resultBytes[8*g +: 8] = 8'hA0 + 8'(g);
  end

  sense_reg_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapA(strapA), .strapB(strapB), .resultBytes(resultBytes),
    .ctrl1Out(ctrl1Out), .ctrl2Out(ctrl2Out), .latchClr(latchClr)
  );

  always @(posedge clk) begin
    if (latchClr) latchCount <= latchCount + 1;
    if (sdaOe) oeSeen <= 1'b1;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitCyc(Q); sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b0; waitCyc(Q); sclM = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitCyc(Q); sclM = 1'b1; waitCyc(Q); sdaM = 1'b1; waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitCyc(Q); sclM = 1'b1; waitCyc(2*Q); sclM = 1'b0;
    end
    sdaM = 1'b1; waitCyc(Q); sclM = 1'b1; waitCyc(Q);
    ack = ~sdaBus;
    waitCyc(Q); sclM = 1'b0; waitCyc(Q);
  endtask

  task automatic recvByte(input logic mack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(Q); sclM = 1'b1; waitCyc(Q); b[i] = sdaBus; waitCyc(Q); sclM = 1'b0;
    end
    sdaM = ~mack; waitCyc(Q); sclM = 1'b1; waitCyc(2*Q); sclM = 1'b0;
    waitCyc(Q); sdaM = 1'b1;
  endtask

  task automatic writeBytes(input logic [7:0] ptr, input logic [7:0] d0,
                            input logic [7:0] d1, input int n);
    logic a;
    ackAll = 1'b1;
    busStart();
    sendByte(addrW, a); ackAll &= a;
    sendByte(ptr, a);   ackAll &= a;
    sendByte(d0, a);    ackAll &= a;
    if (n > 1) begin sendByte(d1, a); ackAll &= a; end
    busStop();
  endtask

  task automatic readRegs(input logic [7:0] ptr, input int n);
    logic a;
    ackAll = 1'b1;
    busStart();
    sendByte(addrW, a); ackAll &= a;
    sendByte(ptr, a);   ackAll &= a;
    busStart();
    sendByte(addrR, a); ackAll &= a;
    for (int k = 0; k < n; k++) recvByte(k < n - 1, rdBuf[k]);
    busStop();
  endtask

  // {pointer, data written, value read back}
  localparam logic [23:0] VEC [8] = '{
    {8'h0A, 8'hE5, 8'hE5},  // R3 control 1 plain write
    {8'h0A, 8'h3F, 8'h2F},  // R8 latch-reset bit reads back 0
    {8'h0B, 8'hFF, 8'h0C},  // R9 reserved bits dropped
    {8'h0B, 8'h08, 8'h08},  // R9 single delay bit
    {8'h03, 8'h55, 8'hA3},  // R7 read-only byte unchanged
    {8'h09, 8'h00, 8'hA9},  // R7 last result byte
    {8'h00, 8'hFF, 8'hA0},  // R7 first result byte
    {8'h0A, 8'h00, 8'h00}   // R3 clear control 1
  };

  initial begin
    waitCyc(190000);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    logic a;
    waitCyc(5);
    chk("R10 ctrl1 in reset", ctrl1Out, 8'h00);
    rstN = 1'b1;
    waitCyc(5);
    chk("R10 ctrl1 after reset", ctrl1Out, 8'h00);
    chk("R10 ctrl2 after reset", ctrl2Out, 8'h00);
    chk("R10 sda released", {7'b0, sdaOe}, 8'h00);

    for (int v = 0; v < 8; v++) begin
      writeBytes(VEC[v][23:16], VEC[v][15:8], 8'h00, 1);
      chk("R1 R3 write acked", {7'b0, ackAll}, 8'h01);
      readRegs(VEC[v][23:16], 1);
      chk("R5 table read", rdBuf[0], VEC[v][7:0]);
    end
    chk("R8 latch pulse count", 8'(latchCount), 8'd1);

    writeBytes(8'h0A, 8'h41, 8'h04, 2);
    chk("R4 burst ctrl1", ctrl1Out, 8'h41);
    chk("R4 burst ctrl2", ctrl2Out, 8'h04);

    readRegs(8'h08, 4);
    chk("R6 burst byte0", rdBuf[0], 8'hA8);
    chk("R6 burst byte1", rdBuf[1], 8'hA9);
    chk("R6 burst byte2", rdBuf[2], 8'h41);
    chk("R6 burst byte3", rdBuf[3], 8'h04);
    chk("R6 released after nack", {7'b0, sdaOe}, 8'h00);

    readRegs(8'h0A, 3);
    chk("R6 saturate byte1", rdBuf[1], 8'h04);
    chk("R6 saturate byte2", rdBuf[2], 8'h04);

    writeBytes(8'h0B, 8'h04, 8'h08, 2);
    chk("R4 saturate ctrl2", ctrl2Out, 8'h08);
    chk("R4 saturate ctrl1", ctrl1Out, 8'h41);

    writeBytes(8'h7F, 8'h0C, 8'h00, 1);
    chk("R11 clamp ctrl2", ctrl2Out, 8'h0C);
    chk("R11 clamp ctrl1", ctrl1Out, 8'h41);

    busStart();
    oeSeen = 1'b0;
    sendByte(8'hF0, a);
    chk("R2 mismatch no ack", {7'b0, a}, 8'h00);
    sendByte(8'h0A, a);
    sendByte(8'h99, a);
    busStop();
    chk("R2 sda never driven", {7'b0, oeSeen}, 8'h00);
    chk("R2 ctrl1 untouched", ctrl1Out, 8'h41);

    strapA = 2'b00; strapB = 2'b00;
    addrW = 8'hE0; addrR = 8'hE1;
    readRegs(8'h0A, 1);
    chk("R1 new strap acked", {7'b0, ackAll}, 8'h01);
    chk("R1 new strap read", rdBuf[0], 8'h41);
    busStart();
    sendByte(8'hF2, a);
    busStop();
    chk("R1 old address ignored", {7'b0, a}, 8'h00);

    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    chk("R10 ctrl1 cleared", ctrl1Out, 8'h00);
    chk("R10 ctrl2 cleared", ctrl2Out, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule